// File: doc/BRIEF.md
# Programmable Watchdog Timer

This block is an 8-bit down-counting watchdog for system supervision. Software turns the timer on, picks a time unit of seconds or minutes, loads a count, arms the timeout output and then sets a run bit. On each unit boundary the count drops by one. When it reaches zero the block raises a sticky status flag and, if armed, drives the timeout output. In normal operation software writes the count again before it runs out, which restarts the countdown.

The unit comes from a 1 Hz tick pulse supplied from outside. Seconds mode uses every tick. Minutes mode divides the tick by 60 inside the block. Reloading the count clears that divider, so each reload starts a full minute. A simple write/read register bus carries all of the control.

Top module: `prog_watchdog`

## Requirements
- R1: After reset the count is 0, all control bits and the status flag are 0, and `timeout_o` is low.
- R2: Register map, 8-bit data. Address 0x00 bit 0 is the timer-on bit. Address 0x01 is control: bit 3 selects minutes (1) or seconds (0), bit 5 is run, and bit 6 reads as the status flag. Address 0x02 writes the count, and a read returns the live count. Address 0x03 bit 0 arms the output. Bits that are not defined read as 0.
- R3: In seconds mode, with both timer-on and run set, each tick pulse lowers a non-zero count by exactly 1.
- R4: In minutes mode, with both timer-on and run set, the count drops by 1 once every 60 tick pulses.
- R5: When a decrement takes the count from 1 to 0, the status flag sets. With the output armed, `timeout_o` goes high in that same cycle.
- R6: When the output is not armed, expiry sets the status flag but `timeout_o` stays low. Arming the output later drives `timeout_o` high while the flag is still set.
- R7: While run is clear or timer-on is clear, ticks leave the count unchanged.
- R8: A count of 0 with run set never expires: the count stays 0 and the status flag stays clear.
- R9: A write to address 0x02 loads the count in the next cycle, even while running. In minutes mode it also restarts the current 60-tick interval.
- R10: Writing control with bit 6 set clears the status flag and drops `timeout_o`. Writing control with bit 6 clear leaves the flag as it is.
- R11: After expiry the count stays at 0 under further ticks and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| tick_i | input | 1 | One-cycle pulse, once per second |
| timeout_o | output | 1 | Timeout drive, status flag ANDed with the arm bit |
| status_o | output | 1 | Sticky expiry flag |

## Verification
Seconds mode counts down to expiry both with the output armed and with it unarmed. This tells the status flag apart from the output drive. Minutes mode is run with 59 and then 60 ticks to locate the divider boundary. A reload partway through a minute checks that the interval restarts and is not carried over. Stopped, timer-off and zero-count cases are each driven with ticks to show that the count holds and nothing expires. A write to control with bit 6 clear, and then one with bit 6 set, confirms the write-one-to-clear behaviour.

// File: rtl/pwd_pkg.sv
// Package: register addresses and field positions shared by the watchdog.
package pwd_pkg;
    localparam logic [7:0] ADDR_ON    = 8'h00;
    localparam logic [7:0] ADDR_CTRL  = 8'h01;
    localparam logic [7:0] ADDR_COUNT = 8'h02;
    localparam logic [7:0] ADDR_ARM   = 8'h03;
    localparam int BIT_UNIT   = 3;
    localparam int BIT_RUN    = 5;
    localparam int BIT_STATUS = 6;
endpackage

// File: rtl/pwd_regs.sv
// Register file. Decodes writes and holds the control bits and the sticky
// status flag. Assumes writes are single-cycle strobes on a synchronous bus.
module pwd_regs
    import pwd_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       addr,
    input  logic [7:0]       wdata,
    input  logic             expire_i,
    input  logic [CNT_W-1:0] count_i,
    output logic [7:0]       rdata,
    output logic             run_o,
    output logic             unit_min_o,
    output logic             arm_o,
    output logic             status_o,
    output logic             load_stb_o,
    output logic [CNT_W-1:0] load_val_o
);
    logic on_q, unit_q, run_q, arm_q, status_q;
    logic wr_ctrl;

    assign wr_ctrl = wr_en && (addr == ADDR_CTRL);

    // Control bit storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            on_q   <= 1'b0;
            unit_q <= 1'b0;
            run_q  <= 1'b0;
            arm_q  <= 1'b0;
        end else if (wr_en) begin
            if (addr == ADDR_ON)  on_q  <= wdata[0];
            if (addr == ADDR_ARM) arm_q <= wdata[0];
            if (wr_ctrl) begin
                unit_q <= wdata[BIT_UNIT];
                run_q  <= wdata[BIT_RUN];
            end
        end
    end

    // Sticky status: set on expiry (set wins), cleared by writing one.
    always_ff @(posedge clk) begin
        if (!rst_n)                           status_q <= 1'b0;
        else if (expire_i)                    status_q <= 1'b1;
        else if (wr_ctrl && wdata[BIT_STATUS]) status_q <= 1'b0;
    end

    // Read mux.
    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_ON:    rdata[0] = on_q;
            ADDR_CTRL: begin
                rdata[BIT_UNIT]   = unit_q;
                rdata[BIT_RUN]    = run_q;
                rdata[BIT_STATUS] = status_q;
            end
            ADDR_COUNT: rdata[CNT_W-1:0] = count_i;
            ADDR_ARM:   rdata[0] = arm_q;
            default:    rdata = '0;
        endcase
    end

    assign run_o      = on_q && run_q;
    assign unit_min_o = unit_q;
    assign arm_o      = arm_q;
    assign status_o   = status_q;
    assign load_stb_o = wr_en && (addr == ADDR_COUNT);
    assign load_val_o = wdata[CNT_W-1:0];
endmodule

// File: rtl/pwd_prescaler.sv
// Unit prescaler. Passes ticks straight through in seconds mode and divides
// them by DIV in minutes mode. Assumes tick_i is a single-cycle pulse.
module pwd_prescaler #(
    parameter int DIV = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic run_i,
    input  logic unit_min_i,
    input  logic clr_i,
    output logic step_o
);
    localparam int PH_W = $clog2(DIV);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);

    logic [PH_W-1:0] phase;
    logic advance;

    assign advance = tick_i && run_i;

    // Phase counter within the current minute.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i || !unit_min_i) phase <= '0;
        else if (advance)                   phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
    end

    assign step_o = advance && (!unit_min_i || (phase == PH_LAST));
endmodule

// File: rtl/pwd_downcount.sv
// Down counter. Loads on strobe and decrements on each step until it reaches
// zero. Reports an expiry pulse on the step that moves it from 1 to 0.
module pwd_downcount #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             step_i,
    output logic [CNT_W-1:0] count_o,
    output logic             expire_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Count register: a load wins over a step, and zero is held.
    always_ff @(posedge clk) begin
        if (!rst_n)                      count_o <= '0;
        else if (load_i)                 count_o <= load_val_i;
        else if (step_i && count_o != 0) count_o <= count_o - ONE;
    end

    assign expire_o = step_i && !load_i && (count_o == ONE);

    assert_zero_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o == 0 && !load_i) |=> (count_o == 0));
    assert_single_decrement_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && count_o != 0) |=> (count_o == $past(count_o) - ONE));
    assert_load_takes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (count_o == $past(load_val_i)));
endmodule

// File: rtl/prog_watchdog.sv
// Top of the programmable watchdog. Connects the register file, the unit
// prescaler and the down counter. Assumes tick_i arrives at 1 Hz as one-cycle pulses.
module prog_watchdog #(
    parameter int CNT_W = 8,
    parameter int DIV   = 60
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       tick_i,
    output logic       timeout_o,
    output logic       status_o
);
    logic             run, unit_min, arm, status, load_stb, step, expire;
    logic [CNT_W-1:0] load_val, count;

    pwd_regs #(.CNT_W(CNT_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .expire_i(expire), .count_i(count), .rdata(rdata), .run_o(run),
        .unit_min_o(unit_min), .arm_o(arm), .status_o(status),
        .load_stb_o(load_stb), .load_val_o(load_val)
    );

    pwd_prescaler #(.DIV(DIV)) presc_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .run_i(run),
        .unit_min_i(unit_min), .clr_i(load_stb), .step_o(step)
    );

    pwd_downcount #(.CNT_W(CNT_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .load_i(load_stb), .load_val_i(load_val),
        .step_i(step), .count_o(count), .expire_o(expire)
    );

    assign timeout_o = status && arm;
    assign status_o  = status;

    assert_expire_from_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status) |-> ($past(count) == CNT_W'(1)));
    assert_step_needs_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> run);
    assert_step_needs_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> tick_i);
endmodule

// File: tb/prog_watchdog_tb.sv
`timescale 1ns/1ps
module prog_watchdog_tb_top;
    logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, tick_i = 1'b0;
    logic [7:0] addr = '0, wdata = '0, rdata;
    logic timeout_o, status_o;
    int checks = 0, fails = 0;

    always #2.5 clk = ~clk;

    prog_watchdog dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .tick_i(tick_i), .timeout_o(timeout_o), .status_o(status_o)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; #1 d = rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_i = 1'b1;
            @(negedge clk); tick_i = 1'b0;
        end
    endtask

    task automatic expect_count(input int exp, input string req);
        logic [7:0] v;
        rd(8'h02, v);
        check(v == exp, req, v, exp);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd(8'h00, v); check(v == 0, "R1 on", v, 0);
        rd(8'h01, v); check(v == 0, "R1 ctrl", v, 0);
        rd(8'h03, v); check(v == 0, "R1 arm", v, 0);
        expect_count(0, "R1 count");
        check(!timeout_o && !status_o, "R1 outputs", timeout_o, 0);
    endtask

    task automatic t_seconds;
        logic [7:0] v;
        wr(8'h00, 8'h01); wr(8'h01, 8'h20); wr(8'h02, 8'd5); wr(8'h03, 8'h01);
        rd(8'h00, v); check(v == 8'h01, "R2 on readback", v, 1);
        ticks(3); expect_count(2, "R3 seconds decrement");
        ticks(1); check(!timeout_o, "R5 before zero", timeout_o, 0);
        ticks(1); expect_count(0, "R5 reaches zero");
        check(timeout_o && status_o, "R5 timeout driven", timeout_o, 1);
        rd(8'h01, v); check(v == 8'h60, "R2 ctrl status bit", v, 8'h60);
        ticks(3); expect_count(0, "R11 no wrap");
    endtask

    task automatic t_w1c;
        logic [7:0] v;
        wr(8'h01, 8'h20); check(status_o && timeout_o, "R10 write zero keeps", status_o, 1);
        wr(8'h01, 8'h60); check(!status_o && !timeout_o, "R10 write one clears", status_o, 0);
        rd(8'h01, v); check(v == 8'h20, "R10 ctrl after clear", v, 8'h20);
    endtask

    task automatic t_zero_count;
        wr(8'h02, 8'd0); ticks(5);
        check(!status_o, "R8 zero never expires", status_o, 0);
        expect_count(0, "R8 count stays zero");
    endtask

    task automatic t_hold;
        wr(8'h02, 8'd10); wr(8'h01, 8'h00); ticks(4);
        expect_count(10, "R7 run clear holds");
        wr(8'h01, 8'h20); wr(8'h00, 8'h00); ticks(3);
        expect_count(10, "R7 timer off holds");
        wr(8'h00, 8'h01); ticks(1);
        expect_count(9, "R7 resumes");
    endtask

    task automatic t_minutes;
        wr(8'h01, 8'h28); wr(8'h02, 8'd3);
        ticks(59); expect_count(3, "R4 59 ticks no step");
        ticks(1);  expect_count(2, "R4 60th tick steps");
        ticks(30); wr(8'h02, 8'd3); expect_count(3, "R9 reload in minutes");
        ticks(59); expect_count(3, "R9 interval restarted");
        ticks(1);  expect_count(2, "R9 full minute after reload");
    endtask

    task automatic t_unarmed;
        wr(8'h03, 8'h00); wr(8'h01, 8'h20); wr(8'h02, 8'd2); ticks(2);
        check(status_o && !timeout_o, "R6 unarmed no drive", timeout_o, 0);
        wr(8'h03, 8'h01); check(timeout_o, "R6 arming drives", timeout_o, 1);
        wr(8'h03, 8'h00); wr(8'h01, 8'h40);
        check(!status_o && !timeout_o, "R10 disable sequence", status_o, 0);
    endtask

    task automatic t_reload_seconds;
        wr(8'h01, 8'h20); wr(8'h02, 8'd5); ticks(2);
        expect_count(3, "R3 second run");
        wr(8'h02, 8'd7); expect_count(7, "R9 reload while running");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_seconds();
        t_w1c();
        t_zero_count();
        t_hold();
        t_minutes();
        t_unarmed();
        t_reload_seconds();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule